// File: doc/BRIEF.md
# Buck Phase Fault Flag Manager

This block watches one phase of a synchronous buck power stage through the digital outputs of its analog comparators. It combines several inputs into one shared three-state fault line and one request to turn the gate driver off. Those inputs are an over-temperature pair (hot and cool), a high-side short comparator, a per-cycle over-current comparator, and two supply-undervoltage indicators. Two one-clock strobes frame each PWM cycle: `pwm_rise` marks the low-to-high transition and `pwm_fall` marks the high-to-low transition.

Each fault type has its own assert and clear rule, counted in PWM cycles or in clocks. Over-temperature is the only fault other than undervoltage that stops switching. Phase faults and over-current faults only raise the flag. Undervoltage pulls the flag line and the current-report line low, and it overrides every other fault.

The flag line has three states, carried on two outputs: driven high (`flag_hi`), weakly pulled low (`flag_lo`), or released (both low).

Top module: `phase_fault_flag`

## Requirements
- R1: After reset, `flag_hi`, `flag_lo`, `isense_lo` and `drv_off` are all 0.
- R2: When `ot_hot` is 1 at a clock edge, `flag_hi` and `drv_off` are 1 after that edge.
- R3: The over-temperature condition stays latched after `ot_hot` falls. It clears at the first edge where `ot_cool` is 1 and `ot_hot` is 0, and `flag_hi` and `drv_off` are then released.
- R4: A phase fault is a `pwm_rise` strobe with `hs_short` at 1. `flag_hi` rises at the edge of the 7th consecutive phase-faulted rise strobe and not before. `drv_off` is not raised by it.
- R5: A `pwm_rise` strobe with `hs_short` at 0 clears the phase-fault flag and its count at that edge.
- R6: A PWM cycle is over-current if `oc_trip` was 1 on any clock since the previous `pwm_fall`, up to and including the current one; the cycle is evaluated at `pwm_fall`. `flag_hi` rises at the 10th consecutive over-current cycle, and a clean cycle before that restarts the count. `drv_off` is not raised by it.
- R7: Once the over-current flag is set, it clears after 3 consecutive clean cycles. An over-current cycle in between restarts that count.
- R8: If `uv_a` or `uv_b` stays 1 for UV_FILT consecutive clocks (default 16), then `flag_lo`, `isense_lo` and `drv_off` are 1 after the UV_FILT-th edge. A shorter pulse has no effect.
- R9: Undervoltage outranks all other faults: while it is active, `flag_hi` is 0. It is released at the first edge where both `uv_a` and `uv_b` are 0.
- R10: While `en` is 0, the phase-fault and over-current counters and flags are held cleared, and PWM strobes are ignored.
- R11: `flag_hi` and `flag_lo` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; 0 clears the PWM-cycle counters |
| pwm_rise | input | 1 | One-clock strobe at the PWM low-to-high transition |
| pwm_fall | input | 1 | One-clock strobe at the PWM high-to-low transition |
| ot_hot | input | 1 | Temperature above the rising threshold |
| ot_cool | input | 1 | Temperature below the falling threshold |
| hs_short | input | 1 | Switch node above the short threshold while the low side conducts |
| oc_trip | input | 1 | Phase current above the limit |
| uv_a | input | 1 | Logic supply undervoltage, unfiltered |
| uv_b | input | 1 | Driver supply undervoltage, unfiltered |
| flag_hi | output | 1 | Fault line driven high |
| flag_lo | output | 1 | Fault line weakly pulled low |
| isense_lo | output | 1 | Current-report output forced low |
| drv_off | output | 1 | Request to turn both switches off |

## Verification
Phase-fault runs of 6 and 7 cycles, and over-current runs of 9 and 10 cycles, show whether the assert thresholds are off by one. A run of 5 faulted cycles, one clean cycle, then 9 faulted cycles shows whether the over-current count really restarts. In the over-current clear sequence, a faulted cycle is placed between clean cycles; this separates "three consecutive clean cycles" from "three clean cycles in total". Undervoltage pulses of 15 and 16 clocks test the glitch filter. Undervoltage held on each supply in turn, with over-temperature latched underneath, shows priority and release on both-clear. A behavioural reference model is compared with every output on every clock.

// File: rtl/phase_fault_flag.sv
module phase_fault_flag #(
  parameter int PF_ASSERT = 7,
  parameter int OC_ASSERT = 10,
  parameter int OC_CLEAR  = 3,
  parameter int UV_FILT   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pwm_rise,
  input  logic pwm_fall,
  input  logic ot_hot,
  input  logic ot_cool,
  input  logic hs_short,
  input  logic oc_trip,
  input  logic uv_a,
  input  logic uv_b,
  output logic flag_hi,
  output logic flag_lo,
  output logic isense_lo,
  output logic drv_off
);
  localparam int PF_W = $clog2(PF_ASSERT + 1);
  localparam int OC_W = $clog2(OC_ASSERT + 1);
  localparam int CL_W = $clog2(OC_CLEAR + 1);
  localparam int UV_W = $clog2(UV_FILT + 1);

  logic            ot_lat;
  logic [PF_W-1:0] pf_cnt;
  logic            pf_flag;
  logic [OC_W-1:0] oc_cnt;
  logic [CL_W-1:0] oc_clean;
  logic            oc_flag;
  logic            oc_seen;
  logic [UV_W-1:0] uv_cnt;
  logic            uv_act;

  wire uv_any   = uv_a | uv_b;
  wire oc_cycle = oc_seen | oc_trip;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ot_lat <= 1'b0;
    else if (ot_hot) ot_lat <= 1'b1;
    else if (ot_cool) ot_lat <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pf_cnt  <= '0;
      pf_flag <= 1'b0;
    end else if (!en) begin
      pf_cnt  <= '0;
      pf_flag <= 1'b0;
    end else if (pwm_rise) begin
      if (hs_short) begin
        if (pf_cnt == PF_W'(PF_ASSERT - 1)) pf_flag <= 1'b1;
        if (pf_cnt != PF_W'(PF_ASSERT)) pf_cnt <= pf_cnt + 1'b1;
      end else begin
        pf_cnt  <= '0;
        pf_flag <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) oc_seen <= 1'b0;
    else if (!en || pwm_fall) oc_seen <= 1'b0;
    else if (oc_trip) oc_seen <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      oc_cnt   <= '0;
      oc_clean <= '0;
      oc_flag  <= 1'b0;
    end else if (!en) begin
      oc_cnt   <= '0;
      oc_clean <= '0;
      oc_flag  <= 1'b0;
    end else if (pwm_fall) begin
      if (oc_cycle) begin
        oc_clean <= '0;
        if (!oc_flag) begin
          if (oc_cnt == OC_W'(OC_ASSERT - 1)) begin
            oc_flag <= 1'b1;
            oc_cnt  <= '0;
          end else oc_cnt <= oc_cnt + 1'b1;
        end
      end else if (!oc_flag) begin
        oc_cnt <= '0;
      end else if (oc_clean == CL_W'(OC_CLEAR - 1)) begin
        oc_flag  <= 1'b0;
        oc_clean <= '0;
      end else oc_clean <= oc_clean + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      uv_cnt <= '0;
      uv_act <= 1'b0;
    end else if (!uv_any) begin
      uv_cnt <= '0;
      uv_act <= 1'b0;
    end else if (!uv_act) begin
      if (uv_cnt == UV_W'(UV_FILT - 1)) uv_act <= 1'b1;
      else uv_cnt <= uv_cnt + 1'b1;
    end

  assign flag_lo   = uv_act;
  assign flag_hi   = !uv_act && (ot_lat || pf_flag || oc_flag);
  assign isense_lo = uv_act;
  assign drv_off   = uv_act || ot_lat;

  AST_OT_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ot_hot |=> drv_off); // R2
  AST_OT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_lat && !ot_cool) |=> ot_lat); // R3
  AST_PF_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_flag) |-> $past(pwm_rise && hs_short)); // R4
  AST_PF_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pwm_rise && !hs_short) |=> !pf_flag); // R5
  AST_OC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oc_flag) |-> $past(pwm_fall && en)); // R6
  AST_UV_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_lo) |-> $past(uv_a || uv_b)); // R8
  AST_UV_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !(uv_a || uv_b) |=> !flag_lo); // R9
  AST_EN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pf_cnt == '0 && oc_cnt == '0 && !pf_flag && !oc_flag)); // R10
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_hi && flag_lo)); // R11
endmodule

// File: tb/phase_fault_flag_test.sv
module phase_fault_flag_test;
  logic clk = 0, rst_n = 0, en = 0;
  logic pwm_rise = 0, pwm_fall = 0, ot_hot = 0, ot_cool = 0;
  logic hs_short = 0, oc_trip = 0, uv_a = 0, uv_b = 0;
  logic flag_hi, flag_lo, isense_lo, drv_off;
  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  phase_fault_flag uut (.*);

  // behavioural reference
  int m_ot = 0, m_pfn = 0, m_pf = 0, m_ocn = 0, m_ocq = 0, m_oc = 0, m_seen = 0, m_uvn = 0, m_uv = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ot = 0; m_pfn = 0; m_pf = 0; m_ocn = 0; m_ocq = 0; m_oc = 0; m_seen = 0; m_uvn = 0; m_uv = 0;
    end else begin
      if (ot_hot) m_ot = 1; else if (ot_cool) m_ot = 0;
      if (!en) begin m_pfn = 0; m_pf = 0; end
      else if (pwm_rise) begin
        if (hs_short) begin m_pfn++; if (m_pfn >= 7) m_pf = 1; end
        else begin m_pfn = 0; m_pf = 0; end
      end
      if (!en) begin m_ocn = 0; m_ocq = 0; m_oc = 0; m_seen = 0; end
      else if (pwm_fall) begin
        if (m_seen || oc_trip) begin
          m_ocq = 0;
          if (!m_oc) begin m_ocn++; if (m_ocn == 10) begin m_oc = 1; m_ocn = 0; end end
        end else if (!m_oc) m_ocn = 0;
        else begin m_ocq++; if (m_ocq == 3) begin m_oc = 0; m_ocq = 0; end end
        m_seen = 0;
      end else if (oc_trip) m_seen = 1;
      if (!(uv_a || uv_b)) begin m_uvn = 0; m_uv = 0; end
      else begin m_uvn++; if (m_uvn >= 16) m_uv = 1; end
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    logic e_lo, e_hi;
    e_lo = (m_uv != 0);
    e_hi = !e_lo && (m_ot != 0 || m_pf != 0 || m_oc != 0);
    check("R9 model flag_hi", flag_hi, e_hi);
    check("R8 model flag_lo", flag_lo, e_lo);
    check("R8 model isense_lo", isense_lo, e_lo);
    check("R2 model drv_off", drv_off, e_lo || m_ot != 0);
    check("R11 exclusive", flag_hi && flag_lo, 1'b0);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pcyc(input logic hs, input logic oc);
    pwm_rise = 1; hs_short = hs; step();
    pwm_rise = 0; hs_short = 0; oc_trip = oc; step();
    oc_trip = 0; pwm_fall = 1; step();
    pwm_fall = 0; step();
  endtask

  initial begin
    step(2);
    rst_n = 1; en = 1;
    step();
    check("R1 flag_hi", flag_hi, 0);
    check("R1 flag_lo", flag_lo, 0);
    check("R1 isense_lo", isense_lo, 0);
    check("R1 drv_off", drv_off, 0);

    ot_hot = 1; step();
    check("R2 flag_hi", flag_hi, 1);
    check("R2 drv_off", drv_off, 1);
    ot_hot = 0; step(5);
    check("R3 latched", flag_hi, 1);
    ot_cool = 1; step();
    check("R3 released flag", flag_hi, 0);
    check("R3 released drv", drv_off, 0);
    ot_cool = 0;

    for (int i = 0; i < 6; i++) pcyc(1, 0);
    check("R4 six cycles", flag_hi, 0);
    pcyc(1, 0);
    check("R4 seventh cycle", flag_hi, 1);
    check("R4 switching kept", drv_off, 0);
    pcyc(0, 0);
    check("R5 clean cycle", flag_hi, 0);

    for (int i = 0; i < 9; i++) pcyc(0, 1);
    check("R6 nine cycles", flag_hi, 0);
    pcyc(0, 1);
    check("R6 tenth cycle", flag_hi, 1);
    check("R6 switching kept", drv_off, 0);
    pcyc(0, 0); pcyc(0, 0); pcyc(0, 1); pcyc(0, 0); pcyc(0, 0);
    check("R7 interrupted clear", flag_hi, 1);
    pcyc(0, 0);
    check("R7 third clean", flag_hi, 0);
    for (int i = 0; i < 5; i++) pcyc(0, 1);
    pcyc(0, 0);
    for (int i = 0; i < 9; i++) pcyc(0, 1);
    check("R6 count restarts", flag_hi, 0);
    pcyc(0, 0);

    uv_a = 1; step(15); uv_a = 0;
    check("R8 glitch ignored", flag_lo, 0);
    step();
    uv_b = 1; step(16);
    check("R8 filtered lo", flag_lo, 1);
    check("R8 isense", isense_lo, 1);
    check("R8 drv_off", drv_off, 1);
    ot_hot = 1; step(); ot_hot = 0;
    check("R9 priority", flag_hi, 0);
    uv_a = 1; step(); uv_b = 0; step(3);
    check("R9 one supply left", flag_lo, 1);
    uv_a = 0; step();
    check("R9 release lo", flag_lo, 0);
    check("R9 hi after release", flag_hi, 1);
    ot_cool = 1; step(); ot_cool = 0;

    en = 0;
    for (int i = 0; i < 7; i++) pcyc(1, 1);
    check("R10 strobes ignored", flag_hi, 0);
    en = 1;
    for (int i = 0; i < 4; i++) pcyc(1, 0);
    en = 0; step(); en = 1;
    for (int i = 0; i < 4; i++) pcyc(1, 0);
    check("R10 count cleared", flag_hi, 0);
    for (int i = 0; i < 3; i++) pcyc(1, 0);
    check("R10 rearmed", flag_hi, 1);
    en = 0; step();
    check("R10 flag cleared", flag_hi, 0);
    en = 1; step(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule